// File: doc/BRIEF.md
# Packet Bit Counter with Compare Event

This block counts the bits of a packet once the radio has seen the packet's address. Counting begins on a start command, and each bit strobe adds one to the count while the counter runs. Software can change the compare value at any time. Each time the count and the compare value become equal, the block emits a one-cycle match pulse.

A start command has an effect only after an address event in the current packet. As an option, the address event can start the counter by itself. A match does not stop the counter. Software can therefore set the compare value to 0 at payload start, then to 16, and get a second event two bytes into the payload. The counter stops and returns to zero on the counter's own stop command and on the radio's end, stop and disable tasks. It also stops on the disabled event.

Top module: `pkt_bitcount`

## Requirements
- R1: After reset the count is 0, the counter is halted, `match_o` is low and the compare value is 0, so the first accepted start gives an immediate match.
- R2: A start command is ignored if no address event has occurred since reset or since the last end, radio stop, disable, disabled or counter stop.
- R3: A start command in or after the cycle of an address event starts the counter from zero. While running, the counter adds one per cycle with `bit_i` high.
- R4: `match_o` is high for exactly one cycle, in the cycle after the counter is running and the count first equals the compare value.
- R5: Counting continues after a match. Writing a new compare value (`cmp_wr_i` with `cmp_data_i`) allows further matches within the same packet.
- R6: A counter stop, radio stop, end, disable or disabled strobe halts the counter and clears the count to zero. No match occurs until a new accepted start.
- R7: With `auto_start_i` high, an address event starts the counter with no start command. With `auto_start_i` low, an address event alone does not start it.
- R8: The count saturates at 2^CNT_W-1 and does not wrap.
- R9: With a compare value of 0 set before the start and 16 written after the start, the block gives one match at the start and one after 16 bit strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bc_start_i | input | 1 | Counter start command strobe |
| bc_stop_i | input | 1 | Counter stop command strobe |
| addr_evt_i | input | 1 | Address event strobe |
| end_i | input | 1 | Radio end task strobe |
| stop_i | input | 1 | Radio stop task strobe |
| disable_i | input | 1 | Radio disable task strobe |
| disabled_i | input | 1 | Radio disabled event strobe |
| bit_i | input | 1 | One strobe per bit sent or received |
| auto_start_i | input | 1 | Shortcut enable: address event starts counter |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_data_i | input | CNT_W | New compare value |
| match_o | output | 1 | One-cycle match event |

## Verification
Every input is sampled at a single clock edge, and `match_o` reflects that edge in the cycle that follows. A start command, a bit strobe or a compare write at edge k therefore produces a pulse during cycle k+1, and a clear at edge k removes any match from cycle k+1 onward. The bench drives each stimulus on the falling edge, then samples `match_o` one nanosecond after the next rising edge. Each expected value therefore belongs to exactly one stimulus cycle. The count is not a port, so the bench makes it visible by rewriting the compare value and checking whether a match appears in the next cycle.

// File: rtl/pkt_bitcount.sv
module pkt_bitcount #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bc_start_i,
  input  logic             bc_stop_i,
  input  logic             addr_evt_i,
  input  logic             end_i,
  input  logic             stop_i,
  input  logic             disable_i,
  input  logic             disabled_i,
  input  logic             bit_i,
  input  logic             auto_start_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             addr_seen, running, eq_q;
  logic [CNT_W-1:0] cnt, cmp;

  wire kill  = bc_stop_i | end_i | stop_i | disable_i | disabled_i;
  wire armed = addr_seen | addr_evt_i;
  wire go    = armed & (bc_start_i | (auto_start_i & addr_evt_i));
  wire eq    = running & (cnt == cmp);

  assign match_o = eq & ~eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_seen <= 1'b0;
      running   <= 1'b0;
      cnt       <= '0;
      cmp       <= '0;
      eq_q      <= 1'b0;
    end else begin
      eq_q <= eq;
      if (cmp_wr_i) cmp <= cmp_data_i;
      if (kill)            addr_seen <= 1'b0;
      else if (addr_evt_i) addr_seen <= 1'b1;
      if (kill) begin
        running <= 1'b0;
        cnt     <= '0;
      end else begin
        if (go) running <= 1'b1;
        if (running && bit_i && cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_bitcount_chk.sv
module pkt_bitcount_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kill,
  input logic             running,
  input logic             addr_seen,
  input logic             addr_evt_i,
  input logic             bit_i,
  input logic [CNT_W-1:0] cnt,
  input logic             match_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(addr_seen || addr_evt_i));

  // R3
  incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && bit_i && !kill && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

  // R4
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);

  // R4
  match_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> running);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!running && cnt == '0 && !match_o));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !kill) |=> cnt == CNT_MAX);
endmodule

bind pkt_bitcount pkt_bitcount_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .kill(kill), .running(running),
  .addr_seen(addr_seen), .addr_evt_i(addr_evt_i), .bit_i(bit_i),
  .cnt(cnt), .match_o(match_o)
);

// File: tb/pkt_bitcount_bench.sv
module pkt_bitcount_bench;
  localparam int W = 12;
  localparam logic [9:0] C_START = 10'b1000000000;
  localparam logic [9:0] C_BCSTP = 10'b0100000000;
  localparam logic [9:0] C_ADDR  = 10'b0010000000;
  localparam logic [9:0] C_END   = 10'b0001000000;
  localparam logic [9:0] C_STOP  = 10'b0000100000;
  localparam logic [9:0] C_DIS   = 10'b0000010000;
  localparam logic [9:0] C_DISD  = 10'b0000001000;
  localparam logic [9:0] C_BIT   = 10'b0000000100;
  localparam logic [9:0] C_SC    = 10'b0000000010;
  localparam logic [9:0] C_WR    = 10'b0000000001;
  localparam logic [9:0] C_NONE  = 10'b0;

  localparam int NV = 28;
  localparam logic [22:0] TBL [0:NV-1] = '{
    {C_START, 12'd0,  1'b0},  // R2 start before address
    {C_ADDR,  12'd0,  1'b0},
    {C_START, 12'd0,  1'b1},  // R3 R9 match at start
    {C_NONE,  12'd0,  1'b0},  // R4 single cycle
    {C_WR,    12'd16, 1'b0},
    {C_BIT, 12'd0, 1'b0}, {C_BIT, 12'd0, 1'b0}, {C_BIT, 12'd0, 1'b0},
    {C_BIT, 12'd0, 1'b0}, {C_BIT, 12'd0, 1'b0}, {C_BIT, 12'd0, 1'b0},
    {C_BIT, 12'd0, 1'b0}, {C_BIT, 12'd0, 1'b0}, {C_BIT, 12'd0, 1'b0},
    {C_BIT, 12'd0, 1'b0}, {C_BIT, 12'd0, 1'b0}, {C_BIT, 12'd0, 1'b0},
    {C_BIT, 12'd0, 1'b0}, {C_BIT, 12'd0, 1'b0}, {C_BIT, 12'd0, 1'b0},
    {C_BIT,   12'd0,  1'b1},  // R9 sixteenth bit
    {C_BIT,   12'd0,  1'b0},  // R5 keeps counting (17)
    {C_WR,    12'd19, 1'b0},
    {C_BIT,   12'd0,  1'b0},
    {C_BIT,   12'd0,  1'b1},  // R5 second match at 19
    {C_END,   12'd0,  1'b0},
    {C_WR,    12'd0,  1'b0},  // R6 halted: no match
    {C_START, 12'd0,  1'b0}   // R2 address cleared by end
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] ctl = '0;
  logic [W-1:0] din = '0;
  logic match_o;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pkt_bitcount #(.CNT_W(W)) u_pkt_bitcount (
    .clk(clk), .rst_n(rst_n),
    .bc_start_i(ctl[9]), .bc_stop_i(ctl[8]), .addr_evt_i(ctl[7]),
    .end_i(ctl[6]), .stop_i(ctl[5]), .disable_i(ctl[4]), .disabled_i(ctl[3]),
    .bit_i(ctl[2]), .auto_start_i(ctl[1]), .cmp_wr_i(ctl[0]),
    .cmp_data_i(din), .match_o(match_o)
  );

  task automatic apply(input logic [9:0] c, input logic [W-1:0] d);
    @(negedge clk);
    ctl = c;
    din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic exp, input string tag);
    nchk++;
    if (match_o !== exp) begin
      nfail++;
      $display("FAIL %s: match_o=%0b expected %0b", tag, match_o, exp);
    end
  endtask

  task automatic clear_case(input logic [9:0] k, input string tag);
    apply(C_END, 12'd0);
    apply(C_WR, 12'd3);
    apply(C_ADDR, 12'd0);
    apply(C_START, 12'd0);
    apply(C_BIT, 12'd0);
    apply(C_BIT, 12'd0);
    apply(k, 12'd0);
    chk(1'b0, tag);
    for (int i = 0; i < 3; i++) begin
      apply(C_BIT, 12'd0);
      chk(1'b0, tag);
    end
    apply(C_WR, 12'd0);
    apply(C_ADDR, 12'd0);
    apply(C_START, 12'd0);
    chk(1'b1, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(1'b0, "R1 reset match low");
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][22:13], TBL[i][12:1]);
      chk(TBL[i][0], $sformatf("R2/R3/R4/R5/R6/R9 vector %0d", i));
    end

    // R1: compare resets to zero
    @(negedge clk);
    rst_n = 1'b0;
    ctl = '0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(C_ADDR, 12'd0);
    apply(C_START, 12'd0);
    chk(1'b1, "R1 reset compare zero");

    // R6: each clearing strobe
    clear_case(C_BCSTP, "R6 counter stop");
    clear_case(C_STOP,  "R6 radio stop");
    clear_case(C_DIS,   "R6 disable");
    clear_case(C_DISD,  "R6 disabled");
    clear_case(C_END,   "R6 end");

    // R7: shortcut
    apply(C_END, 12'd0);
    apply(C_WR, 12'd0);
    apply(C_ADDR, 12'd0);
    chk(1'b0, "R7 no shortcut");
    apply(C_END, 12'd0);
    apply(C_ADDR | C_SC, 12'd0);
    chk(1'b1, "R7 shortcut start");
    apply(C_END, 12'd0);

    // R8: saturation
    apply(C_WR, 12'hFFF);
    apply(C_ADDR, 12'd0);
    apply(C_START, 12'd0);
    chk(1'b0, "R8 start");
    for (int i = 0; i < 4094; i++) apply(C_BIT, 12'd0);
    chk(1'b0, "R8 one short of max");
    apply(C_BIT, 12'd0);
    chk(1'b1, "R8 reach max");
    for (int i = 0; i < 5; i++) begin
      apply(C_BIT, 12'd0);
      chk(1'b0, "R8 past max");
    end
    apply(C_WR, 12'd0);
    chk(1'b0, "R8 compare 0");
    apply(C_WR, 12'hFFF);
    chk(1'b1, "R8 still at max");
    apply(C_NONE, 12'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule